// File: doc/BRIEF.md
# Three-Phase Output Emergency Cutoff

This block guards the six drive lines of a three-phase motor bridge: the three phases and their complements. In normal operation each line's output-enable and data pass straight through from whatever logic drives the pin. When software has armed the cutoff and the active-low emergency input goes low, every one of the six output-enables is pulled inactive, so the pins float at high impedance. This happens no matter which function the pins are serving at the time. The data lines are also held at 0.

The emergency input is asynchronous. It passes through a two-flop synchronizer before the block acts on it. Once the cutoff has engaged it is latched. It lets go only on a cycle where the synchronized emergency input is high and software has disarmed the cutoff. A brief glitch that clears on its own therefore never puts the drive back into a live state.

A byte-wide configuration register holds the arm bit and a reload-timing select bit. The select bit is not used here; it is passed out to a neighbouring timer. Writes to the register land only while a separate unlock input is high. A lock input marks the operating modes in which the reload select must be 0.

Top module: `phase_guard`

## Requirements
- R1: After reset, the arm bit and the reload-select bit are 0 and no cutoff is active, so every `ph_oe_o` and `ph_dat_o` line equals its input.
- R2: While the arm bit is 0 and no cutoff is latched, a low emergency input has no effect on `ph_oe_o` or `ph_dat_o`.
- R3: With the arm bit at 1, an emergency input that goes low drives all six `ph_oe_o` bits to 0 from the third rising clock edge after it falls: two synchronizer stages, then the latch.
- R4: A latched cutoff stays active while the synchronized emergency input is low, and also while the arm bit is 1, even after the emergency input returns high.
- R5: The cutoff releases on the edge that follows a cycle in which the synchronized emergency input is high and the arm bit is 0. From that point the outputs follow their inputs again.
- R6: A register write with `cfg_unlock_i` low leaves the stored register contents unchanged.
- R7: Register layout: bit 1 is the arm bit and bit 0 is the reload select (0 = reload on underflow, 1 = reload on odd-numbered events of the other timer). Bits 7..2 always read 0.
- R8: While `reload_lock_i` is 1, bit 0 of `cfg_rdata_o` and `reload_sel_o` read 0, and a write stores 0 into the reload select. The bit that was stored before the lock reappears once the lock is released.
- R9: While a cutoff is latched, every `ph_dat_o` bit is 0. Otherwise each `ph_dat_o` bit equals its `ph_dat_i` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| estop_ni | input | 1 | Asynchronous active-low emergency input |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_unlock_i | input | 1 | Write protection unlock; writes land only when 1 |
| cfg_wdata_i | input | 8 | Register write data |
| reload_lock_i | input | 1 | Mode indication that forces the reload select to 0 |
| ph_oe_i | input | 6 | Normal output-enables, order U, U-bar, V, V-bar, W, W-bar |
| ph_dat_i | input | 6 | Normal output data, same order |
| ph_oe_o | output | 6 | Gated output-enables to the pads |
| ph_dat_o | output | 6 | Gated output data to the pads |
| cfg_rdata_o | output | 8 | Register read-back |
| reload_sel_o | output | 1 | Effective reload-timing select for the neighbouring timer |

## Verification
The bench drives the emergency input low for exactly the synchronizer window and counts edges. A design with one stage too few or too many cuts off one cycle early or late. The bench also disarms the cutoff while the emergency input is still low, then releases the input. A latch that clears on disarm alone would re-enable the drive too soon, and one that ignores the disarm would never release. Writes with the unlock low, and writes of all ones, show whether a design lets protected writes through or leaks upper bits. Toggling the lock around a stored reload select of 1 shows whether the bit is masked on read or lost for good.

// File: rtl/pg_pkg.sv
package pg_pkg;
    localparam int unsigned PG_REG_W  = 8;
    localparam int unsigned PG_BIT_RL = 0;
    localparam int unsigned PG_BIT_EN = 1;

    typedef struct packed {
        logic arm;
        logic reload;
    } pg_cfg_t;

    typedef struct packed {
        logic cut;
    } pg_cut_t;
endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pg_cfg_reg.sv
module pg_cfg_reg
    import pg_pkg::*;
#(
    parameter int unsigned REG_W  = PG_REG_W,
    parameter int unsigned BIT_EN = PG_BIT_EN,
    parameter int unsigned BIT_RL = PG_BIT_RL
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             we_i,
    input  logic             unlock_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             lock_i,
    output pg_cfg_t          cfg_o,
    output logic [REG_W-1:0] rdata_o
);
    pg_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i && unlock_i) begin
            cfg_d.arm    = wdata_i[BIT_EN];
            cfg_d.reload = wdata_i[BIT_RL] & ~lock_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    always_comb begin
        rdata_o         = '0;
        rdata_o[BIT_EN] = cfg_q.arm;
        rdata_o[BIT_RL] = cfg_q.reload & ~lock_i;
    end

    always_comb begin
        cfg_o        = cfg_q;
        cfg_o.reload = cfg_q.reload & ~lock_i;
    end
endmodule

// File: rtl/pg_cut_latch.sv
module pg_cut_latch
    import pg_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic arm_i,
    input  logic estop_sync_ni,
    output logic cut_o
);
    pg_cut_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cut) begin
            if (estop_sync_ni && !arm_i) st_d.cut = 1'b0;
        end else begin
            if (arm_i && !estop_sync_ni) st_d.cut = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cut_o = st_q.cut;
endmodule

// File: rtl/phase_guard.sv
module phase_guard
    import pg_pkg::*;
#(
    parameter int unsigned N_PH        = 6,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned REG_W       = PG_REG_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             estop_ni,
    input  logic             cfg_we_i,
    input  logic             cfg_unlock_i,
    input  logic [REG_W-1:0] cfg_wdata_i,
    input  logic             reload_lock_i,
    input  logic [N_PH-1:0]  ph_oe_i,
    input  logic [N_PH-1:0]  ph_dat_i,
    output logic [N_PH-1:0]  ph_oe_o,
    output logic [N_PH-1:0]  ph_dat_o,
    output logic [REG_W-1:0] cfg_rdata_o,
    output logic             reload_sel_o
);
    pg_cfg_t cfg;
    logic    estop_s;
    logic    cut_w;

    pg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(estop_ni),
        .sync_o (estop_s)
    );

    pg_cfg_reg #(.REG_W(REG_W)) u_cfg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (cfg_we_i),
        .unlock_i(cfg_unlock_i),
        .wdata_i (cfg_wdata_i),
        .lock_i  (reload_lock_i),
        .cfg_o   (cfg),
        .rdata_o (cfg_rdata_o)
    );

    pg_cut_latch u_latch (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .arm_i        (cfg.arm),
        .estop_sync_ni(estop_s),
        .cut_o        (cut_w)
    );

    for (genvar g = 0; g < N_PH; g++) begin : g_phase
        always_comb begin
            ph_oe_o[g]  = ph_oe_i[g]  & ~cut_w;
            ph_dat_o[g] = ph_dat_i[g] & ~cut_w;
        end
    end

    assign reload_sel_o = cfg.reload;
endmodule

module pg_chk #(
    parameter int unsigned N_PH  = 6,
    parameter int unsigned REG_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             arm,
    input logic             estop_s,
    input logic             cut,
    input logic             we,
    input logic             unlock,
    input logic             lock,
    input logic [REG_W-1:0] rdata,
    input logic [N_PH-1:0]  oe_o
);
    AST_CUT_ENGAGES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arm && !estop_s) |=> (oe_o == '0)); // R3
    AST_HOLD_WHILE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cut && !estop_s) |=> cut); // R4
    AST_HOLD_WHILE_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cut && arm) |=> cut); // R4
    AST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cut && estop_s && !arm) |=> !cut); // R5
    AST_DISARMED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cut && !arm) |=> !cut); // R2
    AST_WRITE_PROTECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we && !unlock) |=> $stable(arm)); // R6
    AST_LOCK_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lock |-> !rdata[0]); // R8
endmodule

bind phase_guard pg_chk #(.N_PH(N_PH), .REG_W(REG_W)) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm    (cfg.arm),
    .estop_s(estop_s),
    .cut    (cut_w),
    .we     (cfg_we_i),
    .unlock (cfg_unlock_i),
    .lock   (reload_lock_i),
    .rdata  (cfg_rdata_o),
    .oe_o   (ph_oe_o)
);

// File: tb/phase_guard_tb.sv
`timescale 1ns/1ps
module phase_guard_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       estop_n = 1'b1;
    logic       we = 1'b0;
    logic       unl = 1'b0;
    logic [7:0] wd = '0;
    logic       lock = 1'b0;
    logic [5:0] oe_in = '0;
    logic [5:0] dat_in = '0;
    logic [5:0] oe_out, dat_out;
    logic [7:0] rd;
    logic       rsel;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic m_s1, m_s2, m_en, m_rl, m_cut;

    always #2 clk = ~clk;

    phase_guard u_dut (
        .clk_i(clk), .rst_ni(rst_n), .estop_ni(estop_n),
        .cfg_we_i(we), .cfg_unlock_i(unl), .cfg_wdata_i(wd),
        .reload_lock_i(lock), .ph_oe_i(oe_in), .ph_dat_i(dat_in),
        .ph_oe_o(oe_out), .ph_dat_o(dat_out), .cfg_rdata_o(rd),
        .reload_sel_o(rsel)
    );

    function automatic logic [7:0] exp_rd();
        return {6'b0, m_en, m_rl & ~lock};
    endfunction

    function automatic logic [5:0] exp_oe();
        return m_cut ? 6'b0 : oe_in;
    endfunction

    function automatic logic [5:0] exp_dat();
        return m_cut ? 6'b0 : dat_in;
    endfunction

    task automatic model_reset();
        m_s1 = 1'b1; m_s2 = 1'b1; m_en = 1'b0; m_rl = 1'b0; m_cut = 1'b0;
    endtask

    task automatic model_edge();
        logic ncut;
        if (!rst_n) begin
            model_reset();
        end else begin
            ncut = m_cut ? !(m_s2 && !m_en) : (m_en && !m_s2);
            m_s2 = m_s1;
            m_s1 = estop_n;
            if (we && unl) begin
                m_en = wd[1];
                m_rl = wd[0] & ~lock;
            end
            m_cut = ncut;
        end
    endtask

    task automatic cmp(string tag, string what, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        cmp(tag, "ph_oe_o", {2'b0, oe_out}, {2'b0, exp_oe()});
        cmp((tag == "R3" || tag == "R4") ? "R9" : tag, "ph_dat_o", {2'b0, dat_out}, {2'b0, exp_dat()});
        cmp(tag == "R1" ? "R1" : "R7", "cfg_rdata_o", rd, exp_rd());
        cmp(tag == "R1" ? "R1" : "R8", "reload_sel_o", {7'b0, rsel}, {7'b0, m_rl & ~lock});
    endtask

    task automatic cyc(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_all(tag);
        we = 1'b0;
    endtask

    task automatic wr(logic [7:0] v, logic u, string tag);
        we = 1'b1; wd = v; unl = u;
        cyc(tag);
        unl = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        model_reset();
        oe_in = 6'h3F; dat_in = 6'h2A;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R2: disarmed, emergency low has no effect
        estop_n = 1'b0;
        for (int i = 0; i < 6; i++) begin oe_in = 6'(i * 7 + 1); cyc("R2"); end
        estop_n = 1'b1;
        repeat (3) cyc("R2");

        // R6: protected write ignored
        wr(8'h03, 1'b0, "R6");
        cmp("R6", "arm after locked write", rd, 8'h00);
        // R7: full write, upper bits read 0
        wr(8'hFF, 1'b1, "R7");
        cmp("R7", "upper bits", rd, 8'h03);
        wr(8'h02, 1'b1, "R7");
        cmp("R7", "arm only", rd, 8'h02);

        // R3: exact engage latency
        oe_in = 6'h3F; dat_in = 6'h15;
        estop_n = 1'b0;
        cyc("R3"); cmp("R3", "not yet cut edge1", {2'b0, oe_out}, 8'h3F);
        cyc("R3"); cmp("R3", "not yet cut edge2", {2'b0, oe_out}, 8'h3F);
        cyc("R3"); cmp("R3", "cut at edge3", {2'b0, oe_out}, 8'h00);
        cmp("R9", "data forced", {2'b0, dat_out}, 8'h00);

        // R4: input back high but still armed
        estop_n = 1'b1;
        repeat (5) cyc("R4");
        cmp("R4", "held while armed", {2'b0, oe_out}, 8'h00);
        // R4: disarm while input low
        estop_n = 1'b0;
        repeat (3) cyc("R4");
        wr(8'h00, 1'b1, "R4");
        repeat (4) cyc("R4");
        cmp("R4", "held while low", {2'b0, oe_out}, 8'h00);
        // R5: release after sync high with arm 0
        estop_n = 1'b1;
        cyc("R5"); cmp("R5", "held edge1", {2'b0, oe_out}, 8'h00);
        cyc("R5"); cmp("R5", "held edge2", {2'b0, oe_out}, 8'h00);
        cyc("R5"); cmp("R5", "released edge3", {2'b0, oe_out}, 8'h3F);
        cmp("R9", "data passes", {2'b0, dat_out}, 8'h15);

        // R8: lock behaviour
        wr(8'h01, 1'b1, "R8");
        cmp("R8", "reload stored", rd, 8'h01);
        lock = 1'b1; #0;
        cyc("R8"); cmp("R8", "masked read", rd, 8'h00);
        cmp("R8", "masked sel", {7'b0, rsel}, 8'h00);
        lock = 1'b0;
        cyc("R8"); cmp("R8", "restored", rd, 8'h01);
        lock = 1'b1;
        wr(8'h01, 1'b1, "R8");
        lock = 1'b0;
        cyc("R8"); cmp("R8", "write under lock stores 0", rd, 8'h00);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 6) estop_n = ~estop_n;
            oe_in  = 6'($urandom);
            dat_in = 6'($urandom);
            lock   = ($urandom_range(0, 9) == 0);
            if ($urandom_range(0, 9) == 0) begin
                we = 1'b1; unl = 1'($urandom); wd = 8'($urandom);
            end
            cyc(m_cut ? "R4" : "R2");
            unl = 1'b0;
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule